// File: doc/BRIEF.md
# Bit-Reversing Block Distributor

The distributor sits at the head of a chain of processing nodes and feeds them data blocks of 1024 points. The points are held in an internal buffer that is loaded through a simple write port. Each block is sent in mirrored-index order: point k of a block carries the buffer word whose 10-bit address is k with its bits reversed. This is the input order that a decimation-in-time FFT spread over the node chain expects. The distributor moves straight on to the next block, so a fresh block enters the chain while older blocks are still being worked on further down.

Three downstream links run to the nearest, second and third node. Each link has 8-bit data, a request and an acknowledge. Every point crosses a link with a four-phase handshake. The nearest link is used first. If a link does not answer within a fixed number of cycles, the distributor abandons it for good and offers the same point on the next farther link. The distributor also gathers a failure flag from every node into one sticky system-failure output. Once that output is set, the distributor goes silent until reset.

Top module: `blk_distrib_top`

## Requirements
- R1: After reset no link request is high, `sysFail` and `blockDone` are low, and the first point offered is point 0 of a block on link 0.
- R2: Within a block, point k (k = 0..1023) carries the buffer word at the address formed by reversing the 10 bits of k (bit 0 of k becomes address bit 9, and so on).
- R3: A point's request stays high with unchanged data until that link's acknowledge is seen. The request then falls. The next point is not offered until the acknowledge is low again, and the point index advances only when this handshake completes.
- R4: When the handshake of point 1023 completes, `blockDone` is high for exactly one cycle. The index then wraps to 0 and the next block follows in the same order.
- R5: Links are tried in order 0, 1, 2. A request held for TRY_CYCLES cycles without an acknowledge moves, with the same point, to the next link. An abandoned link is never requested again until reset.
- R6: At most one link request is high in any cycle.
- R7: If link 2 also times out, the distributor stops offering points and sets `sysFail`.
- R8: If any bit of `nodeFail` is high, `sysFail` is high from the next cycle and stays high until reset, even after `nodeFail` returns low. While `sysFail` is high, every link request is low.
- R9: When `wrEn` is high at a clock edge, `wrData` is stored at `wrAddr`. Writes are accepted while reset is held, and later readout returns the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Buffer write strobe |
| wrAddr | input | 10 | Buffer write address |
| wrData | input | 8 | Buffer write data |
| nodeFail | input | 12 | Failure flag from each node |
| linkReq | output | 3 | Request per link (bit 0 = nearest node) |
| linkAck | input | 3 | Acknowledge per link |
| linkData | output | 3x8 | Data per link, zero on links not selected |
| blockDone | output | 1 | One-cycle pulse after the last point of a block |
| sysFail | output | 1 | Sticky global failure |

## Verification
Some properties are checked by assertions on every cycle: one request at most, data held steady under a standing request, the link pointer only moving forward, a single-cycle done pulse, and the failure latch (set one cycle after a node flag, then sticky, with every request held low). Other behaviour can only be shown by scenarios. These include the mirrored readout order across two whole blocks, the exact request length on a link that never answers, the advance to link 1 or link 2 with the same point, the halt once all links are exhausted, and a rewritten buffer word showing up in the next readout.

// File: rtl/blk_distrib_pkg.sv
package blk_distrib_pkg;

  typedef enum logic [1:0] {
    ST_LOAD = 2'd0,
    ST_SEND = 2'd1,
    ST_DROP = 2'd2,
    ST_HALT = 2'd3
  } distState_t;

  typedef struct packed {
    logic loadData;
    logic advance;
  } distStrobes_t;

endpackage

// File: rtl/blk_distrib_dp.sv
module blk_distrib_dp
  import blk_distrib_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 8,
  parameter int NUM_LINKS = 3,
  parameter int LINK_W    = 2
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               wrEn,
  input  logic [ADDR_W-1:0]                  wrAddr,
  input  logic [DATA_W-1:0]                  wrData,
  input  distStrobes_t                       strobes,
  input  logic [LINK_W-1:0]                  linkSel,
  output logic [NUM_LINKS-1:0][DATA_W-1:0]   linkData,
  output logic                               blockDone
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] sampleMem [DEPTH];
  logic [ADDR_W-1:0] pointIdx;
  logic [ADDR_W-1:0] mirrorIdx;
  logic [DATA_W-1:0] dataReg;
  logic              lastPoint;

  always_ff @(posedge clk) begin
    if (wrEn) sampleMem[wrAddr] <= wrData;
  end

  for (genvar b = 0; b < ADDR_W; b++) begin : g_mirror
    assign mirrorIdx[b] = pointIdx[ADDR_W-1-b];
  end

  assign lastPoint = &pointIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pointIdx  <= '0;
      blockDone <= 1'b0;
    end else begin
      blockDone <= strobes.advance && lastPoint;
      if (strobes.advance) pointIdx <= pointIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 dataReg <= '0;
    else if (strobes.loadData) dataReg <= sampleMem[mirrorIdx];
  end

  for (genvar g = 0; g < NUM_LINKS; g++) begin : g_route
    assign linkData[g] = (linkSel == LINK_W'(g)) ? dataReg : '0;
  end

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    blockDone |=> !blockDone);

endmodule

// File: rtl/blk_distrib_ctrl.sv
module blk_distrib_ctrl
  import blk_distrib_pkg::*;
#(
  parameter int NUM_LINKS  = 3,
  parameter int NUM_NODES  = 12,
  parameter int TRY_CYCLES = 16,
  parameter int LINK_W     = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_NODES-1:0]  nodeFail,
  input  logic [NUM_LINKS-1:0]  linkAck,
  output logic [NUM_LINKS-1:0]  linkReq,
  output logic [LINK_W-1:0]     linkSel,
  output distStrobes_t          strobes,
  output logic                  sysFail
);

  localparam int TIMER_W = $clog2(TRY_CYCLES + 1);

  distState_t        state;
  logic [LINK_W-1:0] curLink;
  logic [TIMER_W-1:0] waitTimer;
  logic              anyNodeFail;
  logic              selAck;
  logic              timeUp;
  logic              onLastLink;

  assign anyNodeFail = |nodeFail;
  assign selAck      = linkAck[curLink];
  assign timeUp      = (waitTimer == TIMER_W'(TRY_CYCLES - 1));
  assign onLastLink  = (curLink == LINK_W'(NUM_LINKS - 1));
  assign linkSel     = curLink;

  always_comb begin
    strobes          = '0;
    strobes.loadData = (state == ST_LOAD);
    strobes.advance  = (state == ST_DROP) && !selAck && !anyNodeFail;
  end

  for (genvar g = 0; g < NUM_LINKS; g++) begin : g_req
    assign linkReq[g] = (state == ST_SEND) && (curLink == LINK_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_LOAD;
      curLink   <= '0;
      waitTimer <= '0;
      sysFail   <= 1'b0;
    end else if (anyNodeFail) begin
      sysFail <= 1'b1;
      state   <= ST_HALT;
    end else begin
      case (state)
        ST_LOAD: begin
          waitTimer <= '0;
          state     <= ST_SEND;
        end
        ST_SEND: begin
          if (selAck) begin
            state <= ST_DROP;
          end else if (timeUp) begin
            waitTimer <= '0;
            if (onLastLink) begin
              state   <= ST_HALT;
              sysFail <= 1'b1;
            end else begin
              curLink <= curLink + 1'b1;
            end
          end else begin
            waitTimer <= waitTimer + 1'b1;
          end
        end
        ST_DROP: begin
          if (!selAck) state <= ST_LOAD;
        end
        default: state <= ST_HALT;
      endcase
    end
  end

  assert_one_req_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(linkReq));

  assert_link_forward_R5: assert property (@(posedge clk) disable iff (!rstN)
    curLink >= $past(curLink));

  assert_fail_follows_node_R8: assert property (@(posedge clk) disable iff (!rstN)
    anyNodeFail |=> sysFail);

  assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    sysFail |=> sysFail);

  assert_quiet_on_fail_R8: assert property (@(posedge clk) disable iff (!rstN)
    sysFail |-> (linkReq == '0));

endmodule

// File: rtl/blk_distrib_top.sv
module blk_distrib_top
  import blk_distrib_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 8,
  parameter int NUM_LINKS  = 3,
  parameter int NUM_NODES  = 12,
  parameter int TRY_CYCLES = 16
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             wrEn,
  input  logic [ADDR_W-1:0]                wrAddr,
  input  logic [DATA_W-1:0]                wrData,
  input  logic [NUM_NODES-1:0]             nodeFail,
  output logic [NUM_LINKS-1:0]             linkReq,
  input  logic [NUM_LINKS-1:0]             linkAck,
  output logic [NUM_LINKS-1:0][DATA_W-1:0] linkData,
  output logic                             blockDone,
  output logic                             sysFail
);

  localparam int LINK_W = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1;

  distStrobes_t      strobes;
  logic [LINK_W-1:0] linkSel;

  blk_distrib_ctrl #(
    .NUM_LINKS(NUM_LINKS), .NUM_NODES(NUM_NODES),
    .TRY_CYCLES(TRY_CYCLES), .LINK_W(LINK_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .nodeFail(nodeFail), .linkAck(linkAck),
    .linkReq(linkReq), .linkSel(linkSel), .strobes(strobes), .sysFail(sysFail)
  );

  blk_distrib_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LINKS(NUM_LINKS), .LINK_W(LINK_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobes(strobes), .linkSel(linkSel), .linkData(linkData),
    .blockDone(blockDone)
  );

  for (genvar g = 0; g < NUM_LINKS; g++) begin : g_hold_chk
    assert_data_held_R3: assert property (@(posedge clk) disable iff (!rstN)
      (linkReq[g] && $past(linkReq[g])) |-> $stable(linkData[g]));
  end

endmodule

// File: tb/blk_distrib_tb.sv
module blk_distrib_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 10;
  localparam int DATA_W     = 8;
  localparam int NLINK      = 3;
  localparam int NNODE      = 12;
  localparam int TRY        = 16;
  localparam int DEPTH      = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [NNODE-1:0]  nodeFail = '0;
  logic [NLINK-1:0]  linkReq;
  logic [NLINK-1:0]  linkAck = '0;
  logic [NLINK-1:0][DATA_W-1:0] linkData;
  logic blockDone;
  logic sysFail;

  blk_distrib_top dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .nodeFail(nodeFail), .linkReq(linkReq), .linkAck(linkAck),
    .linkData(linkData), .blockDone(blockDone), .sysFail(sysFail)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  logic [DATA_W-1:0] modelMem [DEPTH];
  logic [DATA_W-1:0] expQ [$];
  logic [NLINK-1:0] liveMask = '1;
  int expLink = 0;
  int rcv = 0;
  int doneCnt = 0;
  int runLen [NLINK];
  int runCnt [NLINK];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int mirror(input int k);
    int r = 0;
    for (int b = 0; b < ADDR_W; b++) if (k[b]) r |= 1 << (ADDR_W-1-b);
    return r;
  endfunction

  function automatic logic [7:0] pattern(input int a);
    logic [9:0] v = a[9:0];
    return v[7:0] ^ {4{v[9:8]}} ^ 8'h3C;
  endfunction

  task automatic writeWord(input int a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a[ADDR_W-1:0]; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    modelMem[a] = d;
  endtask

  // driver: expected points for the scoreboard
  task automatic pushPoints(input int n);
    for (int k = 0; k < n; k++) expQ.push_back(modelMem[mirror(k % DEPTH)]);
  endtask

  task automatic resetDut();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    expQ.delete();
    rcv = 0;
  endtask

  // monitor / responder
  always @(negedge clk) begin
    if (!rstN) begin
      linkAck = '0;
      doneCnt = 0;
      for (int i = 0; i < NLINK; i++) begin runLen[i] = 0; runCnt[i] = 0; end
    end else begin
      if (blockDone) doneCnt++;
      for (int i = 0; i < NLINK; i++) begin
        if (linkReq[i] && !linkAck[i]) begin
          runLen[i]++;
          if (liveMask[i] && expQ.size() > 0) begin
            check(i == expLink, "R5 link used", i, expLink);
            check(linkData[i] == expQ[0], "R2 point data", int'(linkData[i]), int'(expQ[0]));
            check(doneCnt == rcv / DEPTH, "R4 done count before point", doneCnt, rcv / DEPTH);
            void'(expQ.pop_front());
            rcv++;
            linkAck[i] = 1'b1;
          end
        end else if (!linkReq[i]) begin
          if (runLen[i] > 0) begin
            if (!liveMask[i]) check(runLen[i] == TRY, "R5 timeout length", runLen[i], TRY);
            runCnt[i]++;
            runLen[i] = 0;
          end
          linkAck[i] = 1'b0;
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int bad;
    // R9 preload while reset is held
    @(negedge clk);
    for (int a = 0; a < DEPTH; a++) writeWord(a, pattern(a));

    // Scenario A: all links alive, two whole blocks
    resetDut();
    liveMask = 3'b111; expLink = 0;
    pushPoints(2 * DEPTH);
    rstN = 1'b1;
    check(linkReq == '0, "R1 no request at reset", int'(linkReq), 0);
    check(sysFail == 1'b0, "R1 sysFail low", int'(sysFail), 0);
    check(blockDone == 1'b0, "R1 blockDone low", int'(blockDone), 0);
    wait (rcv == 2 * DEPTH);
    repeat (8) @(negedge clk);
    check(doneCnt == 2, "R4 two block pulses", doneCnt, 2);
    check(runCnt[0] == 2 * DEPTH, "R3 one request per point", runCnt[0], 2 * DEPTH);

    // Scenario B: link 0 dead, fall back to link 1
    resetDut();
    liveMask = 3'b110; expLink = 1;
    pushPoints(40);
    rstN = 1'b1;
    wait (rcv == 40);
    repeat (4) @(negedge clk);
    check(runCnt[0] == 1, "R5 dead link tried once", runCnt[0], 1);

    // Scenario C: links 0 and 1 dead, rewritten word 0 (R9)
    rstN = 1'b0;
    writeWord(0, 8'hA5);
    resetDut();
    liveMask = 3'b100; expLink = 2;
    pushPoints(20);
    check(expQ[0] == 8'hA5, "R9 model word 0", int'(expQ[0]), 8'hA5);
    rstN = 1'b1;
    wait (rcv == 20);
    repeat (4) @(negedge clk);
    check(runCnt[0] == 1, "R5 link0 abandoned", runCnt[0], 1);
    check(runCnt[1] == 1, "R5 link1 abandoned", runCnt[1], 1);

    // Scenario D: all links dead
    resetDut();
    liveMask = 3'b000; expLink = 0;
    rstN = 1'b1;
    repeat (3 * TRY + 10) @(negedge clk);
    check(sysFail == 1'b1, "R7 sysFail after exhaustion", int'(sysFail), 1);
    bad = 0;
    for (int c = 0; c < 40; c++) begin
      if (linkReq != '0) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R7 silent after exhaustion", bad, 0);
    check(runCnt[2] == 1, "R5 link2 tried once", runCnt[2], 1);

    // Scenario E: node failure mid-stream
    resetDut();
    liveMask = 3'b111; expLink = 0;
    pushPoints(5);
    rstN = 1'b1;
    wait (rcv == 5);
    nodeFail = 12'h004;
    @(negedge clk);
    check(sysFail == 1'b1, "R8 sysFail next cycle", int'(sysFail), 1);
    nodeFail = '0;
    bad = 0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (linkReq != '0 || !sysFail) bad++;
    end
    check(bad == 0, "R8 sticky and silent", bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule